// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller gathers 25 maskable interrupt request lines, one non-maskable request and a software reset request, and presents one winner at a time to the CPU. Each maskable line owns one bit in a pair of 16-bit flag registers. The same bit positions in a pair of enable registers and a pair of debug-enable registers qualify it. A one-cycle pulse on a request line sets the flag. A fixed priority table, which does not follow vector numbering, chooses the winner among pending and qualified sources. The controller shows the winner's 5-bit vector number and its byte offset (vector times 8). When the CPU takes the request, the controller drives an active-low acknowledge for one clock and clears the flag of the vector that was taken.

Software reaches the six registers through a simple word port. Writing 1 to a flag bit clears that bit. Enable and debug-enable bits are plain storage. A global mask input holds off every maskable source. When the CPU is halted in real-time debug, a maskable source also needs its debug-enable bit. The non-maskable source and the reset source ignore all of these qualifiers.

Top module: `irq_ctrl`

## Requirements
- R1: `vec_addr_o` always equals `vec_o` multiplied by 8, so vector 31 sits at byte 0xF8.
- R2: Register addresses are: 0 = flag low, 1 = flag high, 2 = enable low, 3 = enable high, 4 = debug-enable low, 5 = debug-enable high. Addresses 6 and 7 read 0. Low bit n (n = 2..15) belongs to vector n. High bit k (k = 0..10) belongs to vector 16+k. Low bits 0..1 and high bits 11..15 always read 0 and ignore writes.
- R3: Among candidates, the winner is the first in this order: 0, 1, 24, 2, 16, 3, 4, 5, 17, 6, 7, 8, 18, 9, 10, 11, 19, 12, 13, 20, 21, 14, 15, 22, 23, 25, 26. `req_o` is high exactly when a candidate exists.
- R4: Hardware reset (`rst_ni` low) clears all six registers and all pending state, and sets `iack_no` high. A `sw_rst_i` pulse clears only the flags, overriding any same-cycle set, and makes vector 0 pending until it is taken.
- R5: With `dbg_halt_i` low, debug-enable bits have no effect. With it high, a maskable vector is a candidate only if both its enable bit and its debug-enable bit are set.
- R6: A take happens when `take_i`, `req_o` and `iack_no` are all high at a clock edge. `iack_no` is then low for exactly the next cycle, and the taken vector's pending flag is cleared.
- R7: A maskable vector whose enable bit is clear is never offered and never acknowledged. Its flag stays set.
- R8: If a set pulse and a clear (acknowledge or write-one-to-clear) hit the same flag in the same cycle, the flag ends up set. The same holds for the non-maskable pending bit.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Enable and debug-enable registers store the written value.
- R10: With `gmask_i` high, no maskable vector is offered. Vectors 0 and 1 are still offered.
- R11: A `nmi_i` pulse makes vector 1 pending regardless of enables and mask. Vector 1 stays pending until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| src_pulse_i | input | 25 | Request pulses; bit i sets the flag of vector i+2 |
| nmi_i | input | 1 | Non-maskable request pulse |
| sw_rst_i | input | 1 | Software reset pulse |
| gmask_i | input | 1 | Global mask of maskable sources |
| dbg_halt_i | input | 1 | CPU halted in real-time debug |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| take_i | input | 1 | CPU accepts the offered vector |
| req_o | output | 1 | A vector is offered |
| vec_o | output | 5 | Offered vector number |
| vec_addr_o | output | 8 | Offered vector byte offset |
| iack_no | output | 1 | Active-low acknowledge pulse |

## Verification
The embedded assertions check these properties on every cycle:
- the acknowledge pulse is one clock wide;
- a taken flag is cleared unless a set arrives with the take;
- a set pulse always lands;
- software reset empties the flags and raises vector 0;
- an offered maskable vector always has its enable bit set, and its debug-enable bit when halted;
- the global mask leaves only vectors 0 and 1.

The priority order and the register map depend on the contents of whole sequences, so only the bench scenarios can show them. The same holds for reserved-bit masking, write-one-to-clear against set collisions, and flags that persist while disabled. The bench compares every output against a reference model each cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NUM_VEC     = 32;
  localparam int VEC_W       = $clog2(NUM_VEC);
  localparam int FIRST_MASK  = 2;
  localparam int LAST_MASK   = 26;
  localparam int NUM_SRC     = LAST_MASK - FIRST_MASK + 1;
  localparam int REG_W       = 16;
  localparam int ADDR_W      = 3;
  localparam int STRIDE_SH   = 3;
  localparam int VADDR_W     = VEC_W + STRIDE_SH;

  localparam logic [NUM_VEC-1:0] VALID_MASK =
    NUM_VEC'(((64'd1 << (LAST_MASK + 1)) - 64'd1) & ~((64'd1 << FIRST_MASK) - 64'd1));

  typedef enum logic [1:0] {
    BANK_FLAG = 2'd0,
    BANK_EN   = 2'd1,
    BANK_DBG  = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  // Fixed service rank per vector; lower wins.
  function automatic logic [VEC_W-1:0] prio_of(input logic [VEC_W-1:0] v);
    logic [VEC_W-1:0] p;
    case (v)
      5'd0:  p = 5'd0;
      5'd1:  p = 5'd1;
      5'd2:  p = 5'd3;
      5'd3:  p = 5'd5;
      5'd4:  p = 5'd6;
      5'd5:  p = 5'd7;
      5'd6:  p = 5'd9;
      5'd7:  p = 5'd10;
      5'd8:  p = 5'd11;
      5'd9:  p = 5'd13;
      5'd10: p = 5'd14;
      5'd11: p = 5'd15;
      5'd12: p = 5'd17;
      5'd13: p = 5'd18;
      5'd14: p = 5'd21;
      5'd15: p = 5'd22;
      5'd16: p = 5'd4;
      5'd17: p = 5'd8;
      5'd18: p = 5'd12;
      5'd19: p = 5'd16;
      5'd20: p = 5'd19;
      5'd21: p = 5'd20;
      5'd22: p = 5'd23;
      5'd23: p = 5'd24;
      5'd24: p = 5'd2;
      5'd25: p = 5'd25;
      5'd26: p = 5'd26;
      default: p = 5'd31;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic               nmi_i,
  input  logic               sw_rst_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               accept_i,
  input  logic [VEC_W-1:0]   acc_vec_i,
  output logic [NUM_VEC-1:0] flag_o,
  output logic [NUM_VEC-1:0] en_o,
  output logic [NUM_VEC-1:0] dbg_o,
  output logic               nmi_pend_o,
  output logic               rst_pend_o
);
  logic [NUM_VEC-1:0] flag_q, en_q, dbg_q;
  logic [NUM_VEC-1:0] wide_data, half_mask, w1c, acc_onehot;
  logic               nmi_q, rst_q;
  bank_e              bank;

  assign bank       = bank_e'(addr_i[ADDR_W-1:1]);
  assign half_mask  = addr_i[0] ? {{REG_W{1'b1}}, {REG_W{1'b0}}} : {{REG_W{1'b0}}, {REG_W{1'b1}}};
  assign wide_data  = addr_i[0] ? {wdata_i, {REG_W{1'b0}}} : {{REG_W{1'b0}}, wdata_i};
  assign w1c        = (we_i && bank == BANK_FLAG) ? (wide_data & half_mask) : '0;
  assign acc_onehot = accept_i ? (NUM_VEC'(1) << acc_vec_i) : '0;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_flag
    if (v >= FIRST_MASK && v <= LAST_MASK) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        flag_q[v] <= 1'b0;
        else if (sw_rst_i)  flag_q[v] <= 1'b0;
        else if (set_i[v])  flag_q[v] <= 1'b1;  // set beats clear
        else if (w1c[v] || acc_onehot[v]) flag_q[v] <= 1'b0;
      end

      p_set_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i[v] && !sw_rst_i) |=> flag_q[v]);
    end else begin : g_rsvd
      assign flag_q[v] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dbg_q <= '0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (we_i && bank == BANK_EN)
        en_q <= ((en_q & ~half_mask) | (wide_data & half_mask)) & VALID_MASK;
      if (we_i && bank == BANK_DBG)
        dbg_q <= ((dbg_q & ~half_mask) | (wide_data & half_mask)) & VALID_MASK;
      nmi_q <= nmi_i || (nmi_q && !acc_onehot[1]);
      rst_q <= sw_rst_i || (rst_q && !acc_onehot[0]);
    end
  end

  logic [NUM_VEC-1:0] rd_bank;
  always_comb begin
    case (bank)
      BANK_FLAG: rd_bank = flag_q;
      BANK_EN:   rd_bank = en_q;
      BANK_DBG:  rd_bank = dbg_q;
      default:   rd_bank = '0;
    endcase
    rdata_o = addr_i[0] ? rd_bank[NUM_VEC-1:REG_W] : rd_bank[REG_W-1:0];
  end

  assign flag_o     = flag_q;
  assign en_o       = en_q;
  assign dbg_o      = dbg_q;
  assign nmi_pend_o = nmi_q;
  assign rst_pend_o = rst_q;

  p_taken_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && (set_i & acc_onehot) == '0 && !nmi_i && !sw_rst_i)
      |=> ((flag_q & $past(acc_onehot)) == '0) &&
          !(nmi_q && $past(acc_onehot[1])) && !(rst_q && $past(acc_onehot[0])));

  p_sw_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> (flag_q == '0) && rst_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] flag_i,
  input  logic [NUM_VEC-1:0] en_i,
  input  logic [NUM_VEC-1:0] dbg_i,
  input  logic               nmi_pend_i,
  input  logic               rst_pend_i,
  input  logic               gmask_i,
  input  logic               halt_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o
);
  logic [NUM_VEC-1:0] qual, cand;
  logic [VEC_W:0]     best_p;

  always_comb begin
    qual = en_i & (halt_i ? dbg_i : '1) & {NUM_VEC{!gmask_i}};
    cand = (flag_i & qual & VALID_MASK) | {{(NUM_VEC-2){1'b0}}, nmi_pend_i, rst_pend_i};
    best_p = {1'b1, {VEC_W{1'b0}}};
    vec_o  = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (cand[v] && {1'b0, prio_of(VEC_W'(v))} < best_p) begin
        best_p = {1'b0, prio_of(VEC_W'(v))};
        vec_o  = VEC_W'(v);
      end
    end
    req_o = |cand;
  end

  p_offer_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && vec_o >= VEC_W'(FIRST_MASK)) |-> en_i[vec_o] && flag_i[vec_o]);

  p_halt_qual_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && halt_i && vec_o >= VEC_W'(FIRST_MASK)) |-> dbg_i[vec_o]);

  p_gmask_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask_i && req_o) |-> vec_o < VEC_W'(FIRST_MASK));

  p_nmi_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_i && !rst_pend_i) |-> req_o && vec_o == VEC_W'(1));
endmodule

// File: rtl/irq_ack.sv
module irq_ack
  import irq_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             accept_o,
  output logic [VEC_W-1:0] acc_vec_o,
  output logic             iack_no
);
  logic iack_q;

  // No take while a pulse is in flight: keeps the pulse one clock wide.
  assign accept_o  = take_i && req_i && iack_q;
  assign acc_vec_o = vec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) iack_q <= 1'b1;
    else         iack_q <= !accept_o;
  end

  assign iack_no = iack_q;

  p_iack_one_clk_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_q |=> iack_q);

  p_iack_follows_take_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && req_i && iack_q) |=> !iack_q);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_pulse_i,
  input  logic               nmi_i,
  input  logic               sw_rst_i,
  input  logic               gmask_i,
  input  logic               dbg_halt_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               take_i,
  output logic               req_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [VADDR_W-1:0] vec_addr_o,
  output logic               iack_no
);
  logic [NUM_VEC-1:0] set_vec, flag, en, dbg;
  logic               nmi_pend, rst_pend, accept, req;
  logic [VEC_W-1:0]   vec, acc_vec;

  assign set_vec = {{(NUM_VEC-LAST_MASK-1){1'b0}}, src_pulse_i, {FIRST_MASK{1'b0}}};

  irq_regs u_regs (
    .clk_i, .rst_ni,
    .set_i      (set_vec),
    .nmi_i,
    .sw_rst_i,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .accept_i   (accept),
    .acc_vec_i  (acc_vec),
    .flag_o     (flag),
    .en_o       (en),
    .dbg_o      (dbg),
    .nmi_pend_o (nmi_pend),
    .rst_pend_o (rst_pend)
  );

  irq_arbiter u_arb (
    .clk_i, .rst_ni,
    .flag_i     (flag),
    .en_i       (en),
    .dbg_i      (dbg),
    .nmi_pend_i (nmi_pend),
    .rst_pend_i (rst_pend),
    .gmask_i,
    .halt_i     (dbg_halt_i),
    .req_o      (req),
    .vec_o      (vec)
  );

  irq_ack u_ack (
    .clk_i, .rst_ni,
    .take_i,
    .req_i      (req),
    .vec_i      (vec),
    .accept_o   (accept),
    .acc_vec_o  (acc_vec),
    .iack_no
  );

  assign req_o      = req;
  assign vec_o      = vec;
  assign vec_addr_o = {vec, {STRIDE_SH{1'b0}}};
endmodule

// File: tb/irq_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [24:0] set_r = '0;
  logic        nmi_r = 0, swr_r = 0, gm_r = 0, halt_r = 0, we_r = 0, take_r = 0;
  logic [2:0]  addr_r = '0;
  logic [15:0] wd_r = '0;
  logic [15:0] rdata;
  logic        req, iack_n;
  logic [4:0]  vec;
  logic [7:0]  vaddr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam logic [31:0] VM = 32'h07FF_FFFC;
  logic [31:0] m_flag = '0, m_en = '0, m_dbg = '0;
  logic        m_nmi = 0, m_rst = 0, m_iack = 1;

  always #2.5 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .src_pulse_i(set_r), .nmi_i(nmi_r), .sw_rst_i(swr_r),
    .gmask_i(gm_r), .dbg_halt_i(halt_r), .reg_we_i(we_r), .reg_addr_i(addr_r),
    .reg_wdata_i(wd_r), .reg_rdata_o(rdata), .take_i(take_r), .req_o(req),
    .vec_o(vec), .vec_addr_o(vaddr), .iack_no(iack_n)
  );

  // Service order, highest first.
  function automatic int order_at(int i);
    int ord [27] = '{0,1,24,2,16,3,4,5,17,6,7,8,18,9,10,11,19,12,13,20,21,14,15,22,23,25,26};
    return ord[i];
  endfunction

  function automatic logic [31:0] cand_of();
    logic [31:0] q;
    q = m_flag & VM & m_en & (halt_r ? m_dbg : 32'hFFFF_FFFF);
    if (gm_r) q = '0;
    q[0] = m_rst;
    q[1] = m_nmi;
    return q;
  endfunction

  function automatic int pick();
    logic [31:0] c = cand_of();
    for (int i = 0; i < 27; i++) if (c[order_at(i)]) return order_at(i);
    return -1;
  endfunction

  function automatic logic [15:0] read_of(logic [2:0] a);
    case (a)
      3'd0: return m_flag[15:0];
      3'd1: return m_flag[31:16];
      3'd2: return m_en[15:0];
      3'd3: return m_en[31:16];
      3'd4: return m_dbg[15:0];
      3'd5: return m_dbg[31:16];
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act %0d exp %0d", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; checks, advances one clock.
  task automatic cycle(string tag);
    int p;
    logic acc;
    logic [31:0] clr, sv, nf;
    #1;
    p = pick();
    chk(tag, "req_o", int'(req), int'(p >= 0));
    if (p >= 0) begin
      chk(tag, "vec_o", int'(vec), p);
      chk("R1", "vec_addr_o", int'(vaddr), p * 8);
    end
    chk("R6", "iack_no", int'(iack_n), int'(m_iack));
    chk(tag, "reg_rdata_o", int'(rdata), int'(read_of(addr_r)));
    acc = take_r && (p >= 0) && m_iack;
    clr = '0;
    if (we_r && addr_r == 3'd0) clr = {16'h0, wd_r};
    if (we_r && addr_r == 3'd1) clr = {wd_r, 16'h0};
    if (acc) clr |= (32'h1 << p);
    sv = {5'b0, set_r, 2'b0};
    nf = swr_r ? '0 : (((m_flag & ~clr) | sv) & VM);
    @(posedge clk);
    m_flag = nf;
    if (we_r && addr_r == 3'd2) m_en[15:0]   = wd_r;
    if (we_r && addr_r == 3'd3) m_en[31:16]  = wd_r;
    if (we_r && addr_r == 3'd4) m_dbg[15:0]  = wd_r;
    if (we_r && addr_r == 3'd5) m_dbg[31:16] = wd_r;
    m_en &= VM;
    m_dbg &= VM;
    m_nmi = nmi_r || (m_nmi && !(acc && p == 1));
    m_rst = swr_r || (m_rst && !(acc && p == 0));
    m_iack = !acc;
    @(negedge clk);
    set_r = '0; nmi_r = 0; swr_r = 0; we_r = 0; take_r = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, string tag);
    we_r = 1; addr_r = a; wd_r = d;
    cycle(tag);
  endtask

  task automatic rd(logic [2:0] a, string tag);
    addr_r = a;
    cycle(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5C_0A71));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4: hardware reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R4");

    // R2 / R9: reserved bits and plain storage
    wr(3'd2, 16'hFFFF, "R9"); rd(3'd2, "R2");
    wr(3'd3, 16'hFFFF, "R9"); rd(3'd3, "R2");
    wr(3'd4, 16'hFFFF, "R9"); wr(3'd5, 16'hFFFF, "R9");
    rd(3'd6, "R2");

    // R3: vector 16 outranks vector 3, vector 24 outranks both
    set_r[1] = 1; set_r[14] = 1; cycle("R3");
    rd(3'd0, "R3");
    set_r[22] = 1; cycle("R3");
    take_r = 1; cycle("R6");  // takes 24
    take_r = 1; cycle("R6");  // blocked while acknowledge is low
    take_r = 1; cycle("R6");  // takes 16
    rd(3'd1, "R6");

    // R9: W1C clears vector 3, writing 0 leaves other bits
    set_r[5] = 1; cycle("R9");
    wr(3'd0, 16'h0008, "R9"); rd(3'd0, "R9");

    // R7: disabled vector stays flagged and is never offered
    wr(3'd2, 16'hFF7F, "R7");  // clear enable of vector 7
    wr(3'd0, 16'hFFFF, "R7");
    set_r[5] = 1; cycle("R7");
    for (int i = 0; i < 6; i++) begin take_r = 1; addr_r = 3'd0; cycle("R7"); end

    // R5: debug-enable ignored running, applied when halted
    wr(3'd2, 16'hFFFF, "R5");
    wr(3'd4, 16'h0000, "R5");
    halt_r = 1; rd(3'd0, "R5");
    halt_r = 0; rd(3'd0, "R5");
    wr(3'd4, 16'h0080, "R5");
    halt_r = 1; take_r = 1; cycle("R5");
    halt_r = 0; rd(3'd0, "R5");

    // R8: set in the same cycle as take of that vector
    set_r[8] = 1; cycle("R8");
    take_r = 1; set_r[8] = 1; cycle("R8");
    rd(3'd0, "R8");
    we_r = 1; addr_r = 3'd0; wd_r = 16'h0400; set_r[8] = 1; cycle("R8");
    rd(3'd0, "R8");

    // R10 / R11: mask blocks maskable, not NMI
    gm_r = 1; rd(3'd0, "R10");
    nmi_r = 1; cycle("R11");
    rd(3'd0, "R11");
    take_r = 1; cycle("R11");
    rd(3'd0, "R10");
    gm_r = 0;

    // R4: software reset clears flags only, raises vector 0
    set_r[3] = 1; cycle("R4");
    swr_r = 1; set_r[4] = 1; cycle("R4");
    rd(3'd0, "R4"); rd(3'd2, "R4"); rd(3'd4, "R4");
    take_r = 1; cycle("R4");
    rd(3'd0, "R4");

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      set_r  = ((r[3:0] == 0) ? 25'($urandom) : 25'(0)) & 25'($urandom);
      nmi_r  = (r[9:4] == 0);
      swr_r  = (r[17:10] == 0);
      gm_r   = (r[20:18] == 0);
      halt_r = (r[23:21] == 0);
      take_r = r[24];
      we_r   = (r[27:25] == 0);
      addr_r = 3'($urandom);
      wd_r   = 16'($urandom);
      cycle("R3");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule